// File: doc/BRIEF.md
# Display Interrupt Register Unit

This block is the small register file that sits between a display controller's event sources and the system interrupt controller. Five event pulses (signal, finish, horizontal sync, vertical sync and area-write-end) each set a sticky status flag. A separate mask register decides which flags may drive the single level interrupt line. Software clears flags by writing ones to them. A command bit restores the whole interrupt state at once.

The signal event carries a data word and a mask word. These merge into a 32-bit signal-ID register. If a second signal event arrives before software has acknowledged the first, it is parked as pending. It stays parked until software writes the signal bit again. The unit also decodes two video-mode registers into a region flag and an interlace flag. It keeps a field indicator that flips at each end of vertical sync.

Writes may be byte, halfword or word wide. A narrow write acts as a full word write with every byte outside the written lanes taken as zero, so unwritten command bits never act. Reads are combinational from the stored state.

Top module: `disp_irq_regs`

## Requirements
- R1: After reset the status flags (control register bits 4:0), the pending flag, the field bit (control bit 13), region, interlace and signal ID are all zero, the mask register (word 1) reads 0x7F00, and irq is low.
- R2: A write to the mask register stores (word & 0x1F00) | 0x6000, where word is the written data placed in its byte lanes.
- R3: irq is high exactly when some status bit n (0..4) is set while mask bit n+8 is clear; it reflects the state one clock after the write or event that changed it.
- R4: An event pulse on ev_pulse[n] (0 signal, 1 finish, 2 hsync, 3 vsync, 4 area-write-end) sets status bit n; a signal event while status bit 0 is clear also updates SIGID to (SIGID & ~sig_mask) | (sig_data & sig_mask).
- R5: A signal event while status bit 0 is already set leaves SIGID unchanged and latches its data and mask words as pending; a later such event overwrites the latched words.
- R6: While a signal is pending, status bit 0 reads 1, so a mask write that leaves bit 8 clear drives irq high.
- R7: Writing control bits 1..4 as one clears the matching status bit; bits written as zero change nothing.
- R8: Writing control bit 9 as one clears all status bits and the pending flag and restores the mask to 0x7F00; SIGID, mode flags and field keep their values.
- R9: Writing control bit 0 as one while a signal is pending sets SIGID to (SIGID & ~pending mask) | (pending data & pending mask), sets status bit 0 and clears the pending flag.
- R10: Writing control bit 0 as one with no signal pending clears status bit 0.
- R11: Byte address bits 1:0 select the lane: a byte write at offset k places data[7:0] at bits 8k+7:8k, a halfword write at offset 2 places data[15:0] at bits 31:16, and all other bits of the word are zero.
- R12: Mode register 1 (word 2) sets region_pal when bits 14:13 of the written word are both one and clears it otherwise; mode register 2 (word 3) bit 0 sets interlaced; reads return region_pal at bits 14:13 and interlaced at bit 0.
- R13: Each vsync_end pulse toggles field.
- R14: An event pulse sets its flag even when a clearing write to the same flag lands in the same cycle, while a reset command in the same cycle as an event leaves all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write (word index in bits ADDR_W-1:2) |
| wr_size | input | 2 | Write width: 0 byte, 1 halfword, 2 or 3 word |
| wr_data | input | 32 | Write data, right-aligned |
| rd_word | input | ADDR_W-2 | Word index for read-back (0 control, 1 mask, 2 mode 1, 3 mode 2, 4 signal ID) |
| rd_data | output | 32 | Combinational read-back data |
| ev_pulse | input | 5 | Single-cycle event pulses, bit order as in R4 |
| sig_data | input | 32 | Data word carried by a signal event |
| sig_mask | input | 32 | Mask word carried by a signal event |
| vsync_end | input | 1 | Single-cycle end-of-vertical-sync pulse |
| irq | output | 1 | Level interrupt request |
| region_pal | output | 1 | Decoded region flag |
| interlaced | output | 1 | Decoded interlace flag |
| field | output | 1 | Field indicator |

## Verification
Every state element is a single register stage. A write or event presented before a rising edge is therefore visible on rd_data, irq and the flag outputs from the following falling edge, and irq adds no further register. The bench drives each stimulus on one falling edge and removes it on the next. It samples at that second falling edge with the combinational read path settled, so every check lands exactly one clock after its cause. The mask/status sweep rebuilds the state with a reset command before each point, so each expected irq value depends only on that point's pattern.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned NSRC      = 5;
  localparam int unsigned MASK_LSB  = 8;
  localparam int unsigned MASK_W    = 15;
  localparam int unsigned PAL_LSB   = 13;
  localparam int unsigned CMD_RESET = 9;
  localparam int unsigned FIELD_BIT = 13;
  localparam int unsigned SRC_SIG   = 0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } wsize_e;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_MASK  = 3'd1,
    REG_MODE1 = 3'd2,
    REG_MODE2 = 3'd3,
    REG_SIGID = 3'd4
  } regsel_e;
endpackage

// File: rtl/dirq_wr_align.sv
module dirq_wr_align import dirq_pkg::*; #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     eff_data,
  output logic              sel_ctrl,
  output logic              sel_mask,
  output logic              sel_mode1,
  output logic              sel_mode2
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0] word_idx;

  assign word_idx = wr_addr[ADDR_W-1:2];

  // lane placement: unwritten lanes are zero
  always_comb begin
    case (wr_size)
      SZ_BYTE: eff_data = {{(DW-8){1'b0}}, wr_data[7:0]} << {wr_addr[1:0], 3'b000};
      SZ_HALF: eff_data = {{(DW-16){1'b0}}, wr_data[15:0]} << {wr_addr[1], 4'b0000};
      default: eff_data = wr_data;
    endcase
  end

  assign sel_ctrl  = wr_en && (word_idx == IW'(REG_CTRL));
  assign sel_mask  = wr_en && (word_idx == IW'(REG_MASK));
  assign sel_mode1 = wr_en && (word_idx == IW'(REG_MODE1));
  assign sel_mode2 = wr_en && (word_idx == IW'(REG_MODE2));
endmodule

// File: rtl/dirq_mask.sv
module dirq_mask import dirq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              mask_wr,
  input  logic [NSRC-1:0]   mask_field,
  output logic [MASK_W-1:0] mask_q
);
  localparam logic [MASK_W-1:0] KEEP  = MASK_W'(((1 << NSRC) - 1) << MASK_LSB);
  localparam logic [MASK_W-1:0] FORCE = ~MASK_W'((1 << (MASK_LSB + NSRC)) - 1);
  localparam logic [MASK_W-1:0] RSTV  = KEEP | FORCE;

  logic [MASK_W-1:0] mask_d;
  logic              mask_en;

  always_comb begin
    mask_en = soft_rst || mask_wr;
    if (soft_rst) mask_d = RSTV;
    else          mask_d = FORCE | (MASK_W'(mask_field) << MASK_LSB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= RSTV;
    else if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/dirq_status.sv
module dirq_status import dirq_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            ctrl_wr,
  input  logic [NSRC-1:0] ctrl_bits,
  input  logic [NSRC-1:0] ev_pulse,
  input  logic [DW-1:0]   sig_data,
  input  logic [DW-1:0]   sig_mask,
  output logic [NSRC-1:0] status_q,
  output logic            pending_q,
  output logic [DW-1:0]   sigid_q
);
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] status_d;
  logic            sig_stat_d;
  logic            pending_d;
  logic [DW-1:0]   sigid_d;
  logic [DW-1:0]   pdata_q, pdata_d;
  logic [DW-1:0]   pmask_q, pmask_d;
  logic            sigid_en;
  logic            pend_en;

  assign clr = ctrl_wr ? ctrl_bits : '0;

  // plain sticky flags: event set wins over write-one clear
  generate
    for (genvar i = 1; i < NSRC; i++) begin : g_flag
      assign status_d[i] = !soft_rst && (ev_pulse[i] || (status_q[i] && !clr[i]));
    end
  endgenerate
  assign status_d[SRC_SIG] = sig_stat_d;

  // signal flag, pending slot and signal-ID merge
  always_comb begin
    sig_stat_d = status_q[SRC_SIG];
    pending_d  = pending_q;
    sigid_d    = sigid_q;
    pdata_d    = pdata_q;
    pmask_d    = pmask_q;
    sigid_en   = 1'b0;
    pend_en    = 1'b0;
    if (clr[SRC_SIG]) begin
      if (pending_q) begin
        sigid_d    = (sigid_q & ~pmask_q) | (pdata_q & pmask_q);
        sigid_en   = 1'b1;
        sig_stat_d = 1'b1;
        pending_d  = 1'b0;
      end else begin
        sig_stat_d = 1'b0;
      end
    end
    if (ev_pulse[SRC_SIG]) begin
      if (sig_stat_d) begin
        pending_d = 1'b1;
        pdata_d   = sig_data;
        pmask_d   = sig_mask;
        pend_en   = 1'b1;
      end else begin
        sigid_d    = (sigid_d & ~sig_mask) | (sig_data & sig_mask);
        sigid_en   = 1'b1;
        sig_stat_d = 1'b1;
      end
    end
    if (soft_rst) begin
      sig_stat_d = 1'b0;
      pending_d  = 1'b0;
      sigid_en   = 1'b0;
      pend_en    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      status_q  <= status_d;
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sigid_q <= '0;
    else if (sigid_en) sigid_q <= sigid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdata_q <= '0;
      pmask_q <= '0;
    end else if (pend_en) begin
      pdata_q <= pdata_d;
      pmask_q <= pmask_d;
    end
  end
endmodule

// File: rtl/dirq_mode.sv
module dirq_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode1_wr,
  input  logic       mode2_wr,
  input  logic [1:0] pal_bits,
  input  logic       ilace_bit,
  input  logic       vsync_end,
  output logic       pal_q,
  output logic       ilace_q,
  output logic       field_q
);
  logic pal_d, ilace_d, field_d;

  always_comb begin
    pal_d   = &pal_bits;
    ilace_d = ilace_bit;
    field_d = !field_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_q   <= 1'b0;
      ilace_q <= 1'b0;
      field_q <= 1'b0;
    end else begin
      if (mode1_wr)  pal_q   <= pal_d;
      if (mode2_wr)  ilace_q <= ilace_d;
      if (vsync_end) field_q <= field_d;
    end
  end
endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs import dirq_pkg::*; #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-3:0] rd_word,
  output logic [DW-1:0]     rd_data,
  input  logic [NSRC-1:0]   ev_pulse,
  input  logic [DW-1:0]     sig_data,
  input  logic [DW-1:0]     sig_mask,
  input  logic              vsync_end,
  output logic              irq,
  output logic              region_pal,
  output logic              interlaced,
  output logic              field
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [DW-1:0]     eff_data;
  logic              sel_ctrl, sel_mask, sel_mode1, sel_mode2;
  logic              soft_rst;
  logic [NSRC-1:0]   status_q;
  logic              pending_q;
  logic [DW-1:0]     sigid_q;
  logic [MASK_W-1:0] mask_q;
  logic              pal_q, ilace_q, field_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  dirq_wr_align #(.ADDR_W(ADDR_W)) u_align (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_size   (wr_size),
    .wr_data   (wr_data),
    .eff_data  (eff_data),
    .sel_ctrl  (sel_ctrl),
    .sel_mask  (sel_mask),
    .sel_mode1 (sel_mode1),
    .sel_mode2 (sel_mode2)
  );

  assign soft_rst = sel_ctrl && eff_data[CMD_RESET];

  dirq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .soft_rst  (soft_rst),
    .ctrl_wr   (sel_ctrl),
    .ctrl_bits (eff_data[NSRC-1:0]),
    .ev_pulse  (ev_pulse),
    .sig_data  (sig_data),
    .sig_mask  (sig_mask),
    .status_q  (status_q),
    .pending_q (pending_q),
    .sigid_q   (sigid_q)
  );

  dirq_mask u_mask (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .soft_rst   (soft_rst),
    .mask_wr    (sel_mask),
    .mask_field (eff_data[MASK_LSB +: NSRC]),
    .mask_q     (mask_q)
  );

  dirq_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .mode1_wr  (sel_mode1),
    .mode2_wr  (sel_mode2),
    .pal_bits  (eff_data[PAL_LSB +: 2]),
    .ilace_bit (eff_data[0]),
    .vsync_end (vsync_end),
    .pal_q     (pal_q),
    .ilace_q   (ilace_q),
    .field_q   (field_q)
  );

  assign irq        = |(status_q & ~mask_q[MASK_LSB +: NSRC]);
  assign region_pal = pal_q;
  assign interlaced = ilace_q;
  assign field      = field_q;

  always_comb begin
    rd_data = '0;
    case (rd_word)
      IW'(REG_CTRL): begin
        rd_data[NSRC-1:0] = status_q;
        rd_data[FIELD_BIT] = field_q;
      end
      IW'(REG_MASK):  rd_data[MASK_W-1:0] = mask_q;
      IW'(REG_MODE1): rd_data[PAL_LSB +: 2] = {2{pal_q}};
      IW'(REG_MODE2): rd_data[0] = ilace_q;
      IW'(REG_SIGID): rd_data = sigid_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dirq_sva.sv
module dirq_sva import dirq_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              ctrl_wr,
  input logic [NSRC-1:0]   ctrl_bits,
  input logic              mask_wr,
  input logic [NSRC-1:0]   ev_pulse,
  input logic [NSRC-1:0]   status_q,
  input logic              pending_q,
  input logic [MASK_W-1:0] mask_q,
  input logic              irq,
  input logic              vsync_end,
  input logic              field
);
  // R8: reset command restores the interrupt state
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mask_q == 15'h7F00 && status_q == '0 && !pending_q));

  // R2: fixed mask bits after any mask write
  p_mask_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !soft_rst) |=> (mask_q[MASK_W-1 -: 2] == 2'b11 && mask_q[MASK_LSB-1:0] == '0));

  // R4: finish event sets its flag
  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse[1] && !soft_rst) |=> status_q[1]);

  // R7: write-one clears the finish flag
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[1] && !ev_pulse[1]) |=> !status_q[1]);

  // R9: signal write releases a pending signal
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[0] && pending_q && !soft_rst && !ev_pulse[0]) |=> (!pending_q && status_q[0]));

  // R6: pending implies signal flag set
  p_pending_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> status_q[0]);

  // R3: an unmasked flag raises irq
  p_irq_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !mask_q[MASK_LSB]) |-> irq);

  // R13: field toggles on each end of vertical sync
  p_field_toggle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_end |=> (field != $past(field)));
endmodule

bind disp_irq_regs dirq_sva u_dirq_sva (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .soft_rst  (soft_rst),
  .ctrl_wr   (sel_ctrl),
  .ctrl_bits (eff_data[dirq_pkg::NSRC-1:0]),
  .mask_wr   (sel_mask),
  .ev_pulse  (ev_pulse),
  .status_q  (status_q),
  .pending_q (pending_q),
  .mask_q    (mask_q),
  .irq       (irq),
  .vsync_end (vsync_end),
  .field     (field_q)
);

// File: tb/test_disp_irq_regs.sv
module test_disp_irq_regs;
  localparam logic [4:0] A_CTRL = 5'h00, A_MASK = 5'h04, A_MODE1 = 5'h08, A_MODE2 = 5'h0C;
  localparam logic [2:0] W_CTRL = 3'd0, W_MASK = 3'd1, W_MODE1 = 3'd2, W_MODE2 = 3'd3, W_SIGID = 3'd4;
  localparam logic [1:0] SZB = 2'b00, SZH = 2'b01, SZW = 2'b10;
  localparam logic [31:0] CMD_RST = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_word = '0;
  logic [31:0] rd_data;
  logic [4:0]  ev_pulse = '0;
  logic [31:0] sig_data = '0;
  logic [31:0] sig_mask = '0;
  logic        vsync_end = 1'b0;
  logic        irq, region_pal, interlaced, field;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_irq_regs i_disp_irq_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .rd_word(rd_word), .rd_data(rd_data), .ev_pulse(ev_pulse),
    .sig_data(sig_data), .sig_mask(sig_mask), .vsync_end(vsync_end), .irq(irq),
    .region_pal(region_pal), .interlaced(interlaced), .field(field)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] ev, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    ev_pulse = ev; sig_data = d; sig_mask = m;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] v);
    rd_word = w;
    #1;
    v = rd_data;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(W_CTRL, v);  check("R1 ctrl", v, 32'h0);
    rd(W_MASK, v);  check("R1 mask", v, 32'h7F00);
    rd(W_SIGID, v); check("R1 sigid", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 modes", {29'b0, region_pal, interlaced, field}, 32'h0);

    // R2 / R11: mask byte sweep at offset 1, and at offset 0
    for (int b = 0; b < 256; b++) begin
      wr(A_MASK + 5'd1, SZB, 32'(b));
      rd(W_MASK, v);
      check("R2 mask byte", v, ((32'(b) << 8) & 32'h1F00) | 32'h6000);
    end
    wr(A_MASK, SZW, 32'hFFFF_FFFF); rd(W_MASK, v); check("R2 mask word", v, 32'h7F00);
    wr(A_MASK, SZB, 32'hFF);        rd(W_MASK, v); check("R11 mask byte0", v, 32'h6000);
    wr(A_MASK, SZH, 32'h1234);      rd(W_MASK, v); check("R11 mask half0", v, 32'h7200);
    wr(A_MASK + 5'd2, SZH, 32'hFFFF); rd(W_MASK, v); check("R11 mask half2", v, 32'h6000);

    // R3 / R4 / R8: status pattern x mask pattern sweep
    for (int s = 1; s < 32; s++) begin
      for (int m = 0; m < 32; m++) begin
        wr(A_CTRL, SZW, CMD_RST);
        pulse(5'(s), 32'h0, 32'h0);
        wr(A_MASK, SZW, 32'(m) << 8);
        check("R3 irq", {31'b0, irq}, {31'b0, ((5'(s) & ~5'(m)) != 5'b0)});
        rd(W_CTRL, v);
        check("R4 flags", v, 32'(s));
      end
    end
    wr(A_CTRL, SZW, CMD_RST);
    rd(W_MASK, v); check("R8 mask restore", v, 32'h7F00);
    rd(W_CTRL, v); check("R8 flags clear", v, 32'h0);

    // R7: write-one-to-clear sweep over bits 1..4
    for (int w = 0; w < 16; w++) begin
      wr(A_CTRL, SZW, CMD_RST);
      pulse(5'h1F, 32'h0, 32'h0);
      wr(A_CTRL, SZW, 32'(w) << 1);
      rd(W_CTRL, v);
      check("R7 w1c", v, 32'h1F & ~(32'(w) << 1));
    end

    // R11: lane placement on the control register
    wr(A_CTRL, SZW, CMD_RST);
    pulse(5'h1F, 32'h0, 32'h0);
    wr(A_MASK, SZW, 32'h0);
    wr(A_CTRL + 5'd2, SZH, 32'hFFFF); rd(W_CTRL, v); check("R11 half2 inert", v, 32'h1F);
    wr(A_CTRL + 5'd2, SZB, 32'hFF);   rd(W_CTRL, v); check("R11 byte2 inert", v, 32'h1F);
    wr(A_CTRL + 5'd3, SZB, 32'hFF);   rd(W_CTRL, v); check("R11 byte3 inert", v, 32'h1F);
    wr(A_CTRL, SZB, 32'h1E);          rd(W_CTRL, v); check("R11 byte0 clear", v, 32'h01);
    wr(A_CTRL + 5'd1, SZB, 32'h02);   rd(W_CTRL, v); check("R11 byte1 reset flags", v, 32'h0);
    rd(W_MASK, v); check("R11 byte1 reset mask", v, 32'h7F00);

    // R4 / R5 / R6 / R9 / R10: signal and pending sequence
    wr(A_MASK, SZW, 32'h0);
    pulse(5'h01, 32'hA5A5_0000, 32'hFFFF_0000);
    rd(W_SIGID, v); check("R4 sigid merge", v, 32'hA5A5_0000);
    check("R4 irq", {31'b0, irq}, 32'h1);
    pulse(5'h01, 32'h0000_1111, 32'h0000_FFFF);
    pulse(5'h01, 32'h0000_2222, 32'h0000_00FF);
    rd(W_SIGID, v); check("R5 sigid held", v, 32'hA5A5_0000);
    rd(W_CTRL, v);  check("R5 flag", v, 32'h01);
    wr(A_MASK, SZW, 32'h0100); check("R6 masked irq", {31'b0, irq}, 32'h0);
    wr(A_MASK, SZW, 32'h0000); check("R6 unmask irq", {31'b0, irq}, 32'h1);
    wr(A_MASK, SZW, 32'h0100);
    wr(A_CTRL, SZW, 32'h1);
    rd(W_SIGID, v); check("R9 sigid release", v, 32'hA5A5_0022);
    rd(W_CTRL, v);  check("R9 flag set", v, 32'h01);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, SZW, 32'h1);
    rd(W_CTRL, v);  check("R10 flag clear", v, 32'h0);
    rd(W_SIGID, v); check("R10 sigid kept", v, 32'hA5A5_0022);

    // R8: reset command drops a pending signal, keeps signal ID
    wr(A_MASK, SZW, 32'h0);
    pulse(5'h01, 32'h0, 32'h0);
    pulse(5'h01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(A_CTRL, SZW, CMD_RST);
    wr(A_CTRL, SZW, 32'h1);
    rd(W_SIGID, v); check("R8 sigid kept", v, 32'hA5A5_0022);
    rd(W_CTRL, v);  check("R8 pending gone", v, 32'h0);

    // R14: same-cycle priorities
    @(negedge clk);
    ev_pulse = 5'h02; wr_en = 1'b1; wr_addr = A_CTRL; wr_size = SZW; wr_data = 32'h02;
    @(negedge clk);
    ev_pulse = '0; wr_en = 1'b0;
    rd(W_CTRL, v); check("R14 set beats clear", v, 32'h02);
    @(negedge clk);
    ev_pulse = 5'h04; wr_en = 1'b1; wr_addr = A_CTRL; wr_size = SZW; wr_data = CMD_RST;
    @(negedge clk);
    ev_pulse = '0; wr_en = 1'b0;
    rd(W_CTRL, v); check("R14 reset beats event", v, 32'h0);

    // R12: mode decode sweep over bits 15:12
    for (int k = 0; k < 16; k++) begin
      wr(A_MODE1, SZW, 32'(k) << 12);
      check("R12 region", {31'b0, region_pal}, {31'b0, ((k >> 1) & 3) == 3});
      rd(W_MODE1, v);
      check("R12 region read", v, (((k >> 1) & 3) == 3) ? 32'h6000 : 32'h0);
    end
    wr(A_MODE1 + 5'd1, SZB, 32'h60); check("R12 byte1 pal", {31'b0, region_pal}, 32'h1);
    wr(A_MODE1, SZB, 32'hFF);        check("R12 byte0 ntsc", {31'b0, region_pal}, 32'h0);
    wr(A_MODE2, SZW, 32'h1);      check("R12 interlace on", {31'b0, interlaced}, 32'h1);
    rd(W_MODE2, v); check("R12 interlace read", v, 32'h1);
    wr(A_MODE2, SZW, 32'hFFFE);   check("R12 interlace off", {31'b0, interlaced}, 32'h0);

    // R13: field toggles
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); vsync_end = 1'b1;
      @(negedge clk); vsync_end = 1'b0;
      rd(W_CTRL, v);
      check("R13 field", v, (t % 2 == 0) ? 32'h2000 : 32'h0);
      check("R13 field port", {31'b0, field}, (t % 2 == 0) ? 32'h1 : 32'h0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule